// File: doc/BRIEF.md
# Two-Way Mailbox Bypass Between Clock Domains

This block gives two ports, each on its own clock, a single-word message path in each direction that bypasses the main data buffer. Port A posts a word into the A-to-B mailbox, and port B collects it. Port B posts a word into the B-to-A mailbox, and port A collects it. A word is 36 bits by default. Each port has one access strobe per cycle. A mailbox-select line on the port decides whether that access goes to the mailboxes or to the neighbouring buffer path. When the select line is low, the access is left for the buffer path and this block ignores it.

Each mailbox has a "mail waiting" flag in the receiving port's domain and an "outbox occupied" flag in the sending port's domain. A write sets the outbox flag. A toggle carries that event across to the receiver, where it raises the waiting flag. When the receiver reads the mail, a second toggle carries the clear back. The sender's outbox stays occupied until that clear has arrived. While the outbox is occupied, further writes are dropped, so mail that has not been read is never overwritten.

Top module: `mbx_bypass`

## Requirements
- R1: During and after a synchronous active-high reset, all of the following are low or zero: both waiting flags, both outbox flags and both read-data outputs.
- R2: A port-A access with `a_en`=1, `a_mbox`=1 and `a_write`=1 while `a_out_busy` is low stores `a_wdata` in the A-to-B mailbox. `a_out_busy` is high from the next `clk_a` cycle. `b_mail_avail` rises within SYNC_STAGES+1 `clk_b` edges.
- R3: A port-B access with `b_en`=1, `b_mbox`=1 and `b_write`=0 while `b_mail_avail` is high places the stored word on `b_rdata` in the next `clk_b` cycle and drops `b_mail_avail` in that same cycle.
- R4: `a_out_busy` stays high after the read until the clear has crossed back to the A side. It falls within SYNC_STAGES+1 `clk_a` edges of the read, and never before the first `clk_a` edge that follows it.
- R5: A mailbox write attempted while the sender's outbox flag is high is dropped. The word already held is the one that is later read.
- R6: The B-to-A mailbox behaves in the same way with the roles swapped: `b_out_busy`, `a_mail_avail`, and `a_rdata` on a port-A read.
- R7: An access with `*_mbox`=0, of either direction, changes no flag and no read-data output.
- R8: A mailbox read while no mail is waiting leaves the read-data output and all flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| rst_a | input | 1 | Port A synchronous reset, active high |
| a_en | input | 1 | Port A access strobe |
| a_write | input | 1 | Port A direction: 1 write, 0 read |
| a_mbox | input | 1 | Port A mailbox select: 1 mailbox, 0 buffer path |
| a_wdata | input | DATA_W | Word written by port A |
| a_rdata | output | DATA_W | Last word collected by port A from the B-to-A mailbox |
| a_mail_avail | output | 1 | B-to-A mail waiting for port A |
| a_out_busy | output | 1 | A-to-B mailbox still occupied |
| clk_b | input | 1 | Port B clock |
| rst_b | input | 1 | Port B synchronous reset, active high |
| b_en | input | 1 | Port B access strobe |
| b_write | input | 1 | Port B direction: 1 write, 0 read |
| b_mbox | input | 1 | Port B mailbox select: 1 mailbox, 0 buffer path |
| b_wdata | input | DATA_W | Word written by port B |
| b_rdata | output | DATA_W | Last word collected by port B from the A-to-B mailbox |
| b_mail_avail | output | 1 | A-to-B mail waiting for port B |
| b_out_busy | output | 1 | B-to-A mailbox still occupied |

## Verification
The case of interest is a new write to a mailbox that arrives in the same sender cycle as the clear returning from the previous read. In that cycle the outbox flag is about to drop, and the write must either be taken cleanly or be dropped cleanly. The bench provokes this by having the sender attempt a write on every cycle while the receiver, on an unrelated clock, reads as soon as mail shows up. The scoreboard judges the outcome: just before each attempt it notes the sender's outbox flag and predicts that only the writes made while the flag is low are accepted. Every word the receiver collects must match those predictions in order, and none may be missing.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int MBX_DATA_W   = 36;
    localparam int MBX_SYNC_DEF = 2;

    typedef enum logic [1:0] {
        ACC_IDLE,
        ACC_BUF,
        ACC_MB_WR,
        ACC_MB_RD
    } acc_e;

    typedef struct packed {
        logic en;
        logic write;
        logic mbox;
    } port_ctl_t;

    function automatic acc_e classify(input port_ctl_t c);
        if (!c.en)   return ACC_IDLE;
        if (!c.mbox) return ACC_BUF;
        return c.write ? ACC_MB_WR : ACC_MB_RD;
    endfunction

endpackage

// File: rtl/mbx_sync.sv
module mbx_sync #(
    parameter int STAGES = mbx_pkg::MBX_SYNC_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[0] <= 1'b0;
                else     chain[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= 1'b0;
                else     chain[g] <= chain[g-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/mbx_channel.sv
module mbx_channel #(
    parameter int DATA_W      = mbx_pkg::MBX_DATA_W,
    parameter int SYNC_STAGES = mbx_pkg::MBX_SYNC_DEF
) (
    input  logic              wclk,
    input  logic              wrst,
    input  logic              wr_go,
    input  logic [DATA_W-1:0] wr_data,
    output logic              w_busy,
    input  logic              rclk,
    input  logic              rrst,
    input  logic              rd_go,
    output logic              r_full,
    output logic              r_take,
    output logic [DATA_W-1:0] r_word
);
    logic [DATA_W-1:0] word_q;
    logic set_tgl, set_seen, clr_tgl, ack_seen;

    // Sender side: holds the word and flips the set toggle on an accepted write
    always_ff @(posedge wclk) begin
        if (wrst) begin
            word_q  <= '0;
            set_tgl <= 1'b0;
        end else if (wr_go && !w_busy) begin
            word_q  <= wr_data;
            set_tgl <= ~set_tgl;
        end
    end

    mbx_sync #(.STAGES(SYNC_STAGES)) u_set_sync (
        .clk(rclk), .rst(rrst), .d(set_tgl), .q(set_seen)
    );

    // Receiver side: flips the clear toggle when it takes the mail
    always_ff @(posedge rclk) begin
        if (rrst)        clr_tgl <= 1'b0;
        else if (r_take) clr_tgl <= ~clr_tgl;
    end

    mbx_sync #(.STAGES(SYNC_STAGES)) u_clr_sync (
        .clk(wclk), .rst(wrst), .d(clr_tgl), .q(ack_seen)
    );

    assign w_busy = set_tgl ^ ack_seen;
    assign r_full = set_seen ^ clr_tgl;
    assign r_take = rd_go && r_full;
    // Stable while r_full is high, since the sender is locked out then
    assign r_word = word_q;
endmodule

// File: rtl/mbx_port.sv
module mbx_port #(
    parameter int DATA_W = mbx_pkg::MBX_DATA_W
) (
    input  logic                clk,
    input  logic                rst,
    input  mbx_pkg::port_ctl_t  ctl,
    input  logic                in_full,
    input  logic [DATA_W-1:0]   in_word,
    output logic                wr_go,
    output logic                rd_go,
    output logic [DATA_W-1:0]   rdata
);
    import mbx_pkg::*;

    acc_e kind;

    assign kind  = classify(ctl);
    assign wr_go = (kind == ACC_MB_WR);
    assign rd_go = (kind == ACC_MB_RD);

    always_ff @(posedge clk) begin
        if (rst)                   rdata <= '0;
        else if (rd_go && in_full) rdata <= in_word;
    end
endmodule

// File: rtl/mbx_bypass.sv
module mbx_bypass #(
    parameter int DATA_W      = mbx_pkg::MBX_DATA_W,
    parameter int SYNC_STAGES = mbx_pkg::MBX_SYNC_DEF
) (
    input  logic              clk_a,
    input  logic              rst_a,
    input  logic              a_en,
    input  logic              a_write,
    input  logic              a_mbox,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    output logic              a_mail_avail,
    output logic              a_out_busy,
    input  logic              clk_b,
    input  logic              rst_b,
    input  logic              b_en,
    input  logic              b_write,
    input  logic              b_mbox,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_rdata,
    output logic              b_mail_avail,
    output logic              b_out_busy
);
    import mbx_pkg::*;

    port_ctl_t         ctl_a, ctl_b;
    logic              a_wr_go, a_rd_go, b_wr_go, b_rd_go;
    logic              ab_take, ba_take;
    logic [DATA_W-1:0] ab_word, ba_word;

    assign ctl_a = '{en: a_en, write: a_write, mbox: a_mbox};
    assign ctl_b = '{en: b_en, write: b_write, mbox: b_mbox};

    mbx_port #(.DATA_W(DATA_W)) u_port_a (
        .clk(clk_a), .rst(rst_a), .ctl(ctl_a),
        .in_full(a_mail_avail), .in_word(ba_word),
        .wr_go(a_wr_go), .rd_go(a_rd_go), .rdata(a_rdata)
    );

    mbx_port #(.DATA_W(DATA_W)) u_port_b (
        .clk(clk_b), .rst(rst_b), .ctl(ctl_b),
        .in_full(b_mail_avail), .in_word(ab_word),
        .wr_go(b_wr_go), .rd_go(b_rd_go), .rdata(b_rdata)
    );

    // A-to-B mailbox
    mbx_channel #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_ab (
        .wclk(clk_a), .wrst(rst_a), .wr_go(a_wr_go), .wr_data(a_wdata),
        .w_busy(a_out_busy),
        .rclk(clk_b), .rrst(rst_b), .rd_go(b_rd_go),
        .r_full(b_mail_avail), .r_take(ab_take), .r_word(ab_word)
    );

    // B-to-A mailbox
    mbx_channel #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_ba (
        .wclk(clk_b), .wrst(rst_b), .wr_go(b_wr_go), .wr_data(b_wdata),
        .w_busy(b_out_busy),
        .rclk(clk_a), .rrst(rst_a), .rd_go(a_rd_go),
        .r_full(a_mail_avail), .r_take(ba_take), .r_word(ba_word)
    );
endmodule

// File: rtl/mbx_bypass_chk.sv
module mbx_bypass_chk #(
    parameter int DATA_W = mbx_pkg::MBX_DATA_W
) (
    input logic              clk_a,
    input logic              rst_a,
    input logic              a_en,
    input logic              a_write,
    input logic              a_mbox,
    input logic [DATA_W-1:0] a_rdata,
    input logic              a_mail_avail,
    input logic              a_out_busy,
    input logic              clk_b,
    input logic              rst_b,
    input logic              b_en,
    input logic              b_write,
    input logic              b_mbox,
    input logic [DATA_W-1:0] b_rdata,
    input logic              b_mail_avail,
    input logic              b_out_busy
);
    logic a_wr, a_rd, b_wr, b_rd;
    assign a_wr = a_en && a_mbox && a_write;
    assign a_rd = a_en && a_mbox && !a_write;
    assign b_wr = b_en && b_mbox && b_write;
    assign b_rd = b_en && b_mbox && !b_write;

    p_busy_on_write_r2: assert property (@(posedge clk_a) disable iff (rst_a)
        (a_wr && !a_out_busy) |=> a_out_busy);

    p_clear_on_read_r3: assert property (@(posedge clk_b) disable iff (rst_b)
        (b_rd && b_mail_avail) |=> !b_mail_avail);

    p_flag_holds_r4: assert property (@(posedge clk_b) disable iff (rst_b)
        (b_mail_avail && !b_rd) |=> b_mail_avail);

    p_busy_on_write_r6: assert property (@(posedge clk_b) disable iff (rst_b)
        (b_wr && !b_out_busy) |=> b_out_busy);

    p_clear_on_read_r6: assert property (@(posedge clk_a) disable iff (rst_a)
        (a_rd && a_mail_avail) |=> !a_mail_avail);

    p_buf_access_quiet_r7: assert property (@(posedge clk_b) disable iff (rst_b)
        (b_en && !b_mbox) |=> $stable(b_rdata));

    p_rdata_stable_b_r8: assert property (@(posedge clk_b) disable iff (rst_b)
        !(b_rd && b_mail_avail) |=> $stable(b_rdata));

    p_rdata_stable_a_r8: assert property (@(posedge clk_a) disable iff (rst_a)
        !(a_rd && a_mail_avail) |=> $stable(a_rdata));
endmodule

bind mbx_bypass mbx_bypass_chk #(.DATA_W(DATA_W)) u_chk (
    .clk_a(clk_a), .rst_a(rst_a), .a_en(a_en), .a_write(a_write), .a_mbox(a_mbox),
    .a_rdata(a_rdata), .a_mail_avail(a_mail_avail), .a_out_busy(a_out_busy),
    .clk_b(clk_b), .rst_b(rst_b), .b_en(b_en), .b_write(b_write), .b_mbox(b_mbox),
    .b_rdata(b_rdata), .b_mail_avail(b_mail_avail), .b_out_busy(b_out_busy)
);

// File: tb/mbx_bypass_tb.sv
module mbx_bypass_tb;
    localparam int CLK_PERIOD   = 10;
    localparam int CLK_B_PERIOD = CLK_PERIOD + 4;
    localparam int DW           = 36;

    logic clk_a = 1'b0, clk_b = 1'b0;
    logic rst_a = 1'b1, rst_b = 1'b1;
    logic a_en = 0, a_write = 0, a_mbox = 0;
    logic b_en = 0, b_write = 0, b_mbox = 0;
    logic [DW-1:0] a_wdata = '0, b_wdata = '0;
    logic [DW-1:0] a_rdata, b_rdata;
    logic a_mail_avail, a_out_busy, b_mail_avail, b_out_busy;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit rd_live_a = 0, rd_live_b = 0;
    logic [DW-1:0] q_ab[$];
    logic [DW-1:0] q_ba[$];
    int got_ab = 0;

    always #(CLK_PERIOD/2)   clk_a = ~clk_a;
    always #(CLK_B_PERIOD/2) clk_b = ~clk_b;

    mbx_bypass #(.DATA_W(DW)) u_dut (.*);

    task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Driver tasks: each drives at the next negedge and leaves the strobe on
    task automatic a_send(input logic [DW-1:0] d);
        @(negedge clk_a);
        if (!a_out_busy) q_ab.push_back(d);
        a_en = 1; a_write = 1; a_mbox = 1; a_wdata = d; rd_live_a = 0;
    endtask
    task automatic a_recv();
        @(negedge clk_a);
        rd_live_a = a_mail_avail;
        a_en = 1; a_write = 0; a_mbox = 1;
    endtask
    task automatic a_idle();
        @(negedge clk_a);
        a_en = 0; rd_live_a = 0;
    endtask
    task automatic b_send(input logic [DW-1:0] d);
        @(negedge clk_b);
        if (!b_out_busy) q_ba.push_back(d);
        b_en = 1; b_write = 1; b_mbox = 1; b_wdata = d; rd_live_b = 0;
    endtask
    task automatic b_recv();
        @(negedge clk_b);
        rd_live_b = b_mail_avail;
        b_en = 1; b_write = 0; b_mbox = 1;
    endtask
    task automatic b_idle();
        @(negedge clk_b);
        b_en = 0; rd_live_b = 0;
    endtask

    // Monitors: compare collected words against the scoreboard queues
    always @(posedge clk_b) begin
        if (!rst_b && rd_live_b) begin
            #2;
            if (q_ab.size() == 0) chk(0, "R3 unexpected A-to-B mail", b_rdata, '0);
            else begin
                logic [DW-1:0] e;
                e = q_ab.pop_front();
                got_ab++;
                chk(b_rdata == e, "R3/R5 A-to-B word", b_rdata, e);
            end
        end
    end
    always @(posedge clk_a) begin
        if (!rst_a && rd_live_a) begin
            #2;
            if (q_ba.size() == 0) chk(0, "R6 unexpected B-to-A mail", a_rdata, '0);
            else begin
                logic [DW-1:0] e;
                e = q_ba.pop_front();
                chk(a_rdata == e, "R6 B-to-A word", a_rdata, e);
            end
        end
    end

    initial begin
        #(CLK_B_PERIOD * 200000);
        if (!done) begin
            chk(0, "watchdog", '0, '1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] held;
        repeat (6) @(negedge clk_b);
        // R1 reset state
        chk(!a_mail_avail && !b_mail_avail, "R1 waiting flags in reset", {a_mail_avail, b_mail_avail}, '0);
        chk(!a_out_busy && !b_out_busy, "R1 outbox flags in reset", {a_out_busy, b_out_busy}, '0);
        @(negedge clk_a); rst_a = 0;
        @(negedge clk_b); rst_b = 0;
        repeat (2) @(negedge clk_b);
        chk(a_rdata == '0 && b_rdata == '0, "R1 read data after reset", a_rdata | b_rdata, '0);

        // R2 write A-to-B
        a_send(36'h1_2345_6789);
        a_idle();
        chk(a_out_busy == 1'b1, "R2 outbox busy after write", a_out_busy, 1);
        repeat (4) @(negedge clk_b);
        chk(b_mail_avail == 1'b1, "R2 mail waiting at B", b_mail_avail, 1);

        // R5 write while occupied is dropped (driver does not queue it)
        a_send(36'hB_AD00_0BAD);
        a_idle();
        chk(a_out_busy == 1'b1, "R5 outbox still busy", a_out_busy, 1);

        // R7 buffer-path accesses leave the mailboxes alone
        @(negedge clk_b);
        b_en = 1; b_mbox = 0; b_write = 0;
        @(negedge clk_b);
        b_en = 0;
        @(negedge clk_b);
        chk(b_rdata == '0, "R7 rdata unchanged by buffer read", b_rdata, '0);
        chk(b_mail_avail == 1'b1, "R7 flag unchanged by buffer read", b_mail_avail, 1);

        // R3 read, R4 clear round trip
        b_recv();
        b_idle();
        chk(b_mail_avail == 1'b0, "R3 flag clears after read", b_mail_avail, 0);
        chk(a_out_busy == 1'b1, "R4 outbox held until clear returns", a_out_busy, 1);
        repeat (4) @(negedge clk_a);
        chk(a_out_busy == 1'b0, "R4 outbox released", a_out_busy, 0);

        // R8 read with nothing waiting
        held = b_rdata;
        b_recv();
        b_idle();
        chk(b_rdata == held, "R8 rdata unchanged on empty read", b_rdata, held);
        chk(!b_mail_avail && !a_out_busy, "R8 flags unchanged on empty read", {b_mail_avail, a_out_busy}, '0);

        // R6 B-to-A direction, plus a dropped second write and an A buffer write (R7)
        b_send(36'hF_EDCB_A987);
        b_send(36'h0_0000_0001);
        b_idle();
        chk(b_out_busy == 1'b1, "R6 B outbox busy", b_out_busy, 1);
        @(negedge clk_a);
        a_en = 1; a_mbox = 0; a_write = 1; a_wdata = 36'h5_5555_5555;
        @(negedge clk_a);
        a_en = 0;
        repeat (4) @(negedge clk_a);
        chk(a_mail_avail == 1'b1, "R6 mail waiting at A", a_mail_avail, 1);
        chk(b_mail_avail == 1'b0, "R7 buffer write raised no flag", b_mail_avail, 0);
        a_recv();
        a_idle();
        chk(a_mail_avail == 1'b0, "R6 A flag clears", a_mail_avail, 0);
        repeat (5) @(negedge clk_b);
        chk(b_out_busy == 1'b0, "R6 B outbox released", b_out_busy, 0);

        // Stress: writer hammers every cycle, reader takes mail as it appears
        got_ab = 0;
        fork
            begin
                for (int i = 0; i < 80; i++) a_send(36'hA_0000_0000 + 36'(i));
                a_idle();
            end
            begin
                for (int j = 0; j < 70; j++) b_recv();
                b_idle();
            end
        join
        repeat (6) @(negedge clk_b);
        if (b_mail_avail) begin b_recv(); b_idle(); end
        repeat (3) @(negedge clk_b);
        chk(q_ab.size() == 0, "R5 every accepted word collected", DW'(q_ab.size()), '0);
        chk(got_ab >= 4, "R2 several words crossed under load", DW'(got_ab), 4);
        chk(q_ba.size() == 0, "R6 B-to-A queue drained", DW'(q_ba.size()), '0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule